// File: doc/BRIEF.md
# Multi-Channel Pin Interrupt Controller

This block watches eight pin-derived inputs and raises a single interrupt when any channel sees the event it is configured for. A shared 3-bit port select picks one of six I/O ports. Every channel then takes the bit of that port that matches its own index. Each channel chooses edge or level detection and has separate enables for the high/rising sense and the low/falling sense. A detected event sets that channel's sticky flag. Software clears flags by writing zeros through a simple write strobe.

Pins pass through a two-flop synchronizer before detection. A change of port select or detection type never produces an edge event. A wake output combines the interrupt with a purely combinational match of level-mode channels on the raw pins, so it works while the clock is stopped.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After synchronous reset, all flags, `irq` and `wake` are 0.
- R2: Select codes 0..5 route bit n of port p (`port_in[p*8+n]`) to channel n. Codes 6 and 7 make every channel inactive.
- R3: Channel 7 is inactive for select codes 3 and 4 and never sets its flag there. Channel 6 on the same code still works.
- R4: In edge mode (type bit 0), the positive enable detects rising edges and the negative enable detects falling edges. A pin change driven before clock edge k shows in the flag after edge k+2.
- R5: In level mode (type bit 1), the positive enable detects a high level and the negative enable detects a low level, on every cycle the level holds.
- R6: Both enables may be set, catching both senses. With neither set, the channel never sets its flag.
- R7: A write with `flag_wr` high clears each flag whose `flag_wdata` bit is 0 and keeps each flag whose bit is 1. Flags change only through detection or such a write.
- R8: A hardware set in the same cycle as a software clear leaves the flag set, so a level-mode flag reappears while its level persists.
- R9: `irq` is high exactly when at least one flag is set.
- R10: Changing the port select or a channel's type bit creates no edge event in that cycle.
- R11: `wake` is high when `irq` is high. It is also high, with no clock edge needed, when an active level-mode channel's raw selected pin is at an enabled level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | 48 | Six 8-bit ports, port p at bits p*8+7..p*8 |
| port_sel | input | 3 | Shared port select |
| chan_level | input | 8 | Per-channel type: 1 level, 0 edge |
| chan_pos_en | input | 8 | Per-channel high/rising enable |
| chan_neg_en | input | 8 | Per-channel low/falling enable |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 8 | Write data: 0 clears, 1 keeps |
| flag_q | output | 8 | Sticky per-channel flags |
| irq | output | 1 | OR of all flags |
| wake | output | 1 | Wake request, partly combinational |

## Verification
The bench probes the three-edge latency from pin to flag. A design with one synchronizer stage too many or too few would set the flag a cycle late or early. It switches the port select onto a port whose bit differs from the old one. A design that compares against a stale sample would then raise a false edge flag. It drives channel 7 from reserved codes with low-level sensing, which a missing reserved check would flag at once. It also clears a level-mode flag while the level is still held; a design where the clear wins would show a zero. A constrained-random phase compares flags and wake against a bench model every cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
    localparam int NUM_CH   = 8;
    localparam int NUM_PORT = 6;
    localparam int SEL_W    = 3;
    localparam int RSV_CH   = 7;
    localparam int RSV_LO   = 3;
    localparam int RSV_HI   = 4;

    typedef struct packed {
        logic level;   // 1: level sense, 0: edge sense
        logic hi_en;   // high level / rising edge
        logic lo_en;   // low level / falling edge
    } ch_cfg_t;

    function automatic logic sel_ok(input int ch, input logic [SEL_W-1:0] sel);
        if (int'(sel) >= NUM_PORT) return 1'b0;
        if (ch == RSV_CH && int'(sel) >= RSV_LO && int'(sel) <= RSV_HI) return 1'b0;
        return 1'b1;
    endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pin_chan_det.sv
module pin_chan_det
    import pin_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_cfg_t cfg,
    input  logic    cfg_chg,
    input  logic    valid,
    input  logic    cur_i,
    input  logic    raw_i,
    output logic    hit_o,
    output logic    wake_o
);
    logic prev_q;
    logic rise, fall, lvl_hit, edge_hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cur_i;   // always reloaded, so a config change leaves no stale sample
    end

    always_comb begin
        rise     = cur_i & ~prev_q;
        fall     = ~cur_i & prev_q;
        lvl_hit  = (cfg.hi_en & cur_i) | (cfg.lo_en & ~cur_i);
        edge_hit = ~cfg_chg & ((cfg.hi_en & rise) | (cfg.lo_en & fall));
        hit_o    = valid & (cfg.level ? lvl_hit : edge_hit);
        wake_o   = valid & cfg.level & ((cfg.hi_en & raw_i) | (cfg.lo_en & ~raw_i));
    end

    assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg.level && hit_o) |-> (cur_i != $past(cur_i)));
endmodule

// File: rtl/pin_flag_reg.sv
module pin_flag_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] flag_q
);
    logic [N-1:0] keep_mask;

    assign keep_mask = wr_en ? wr_data : {N{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & keep_mask) | set_i;
    end

    assert_clear_by_sw_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(flag_q) & ~flag_q &
                   ($past(wr_en) ? $past(wr_data) : {N{1'b1}})) == '0));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int NPORT = NUM_PORT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPORT*NCH-1:0]  port_in,
    input  logic [SEL_W-1:0]      port_sel,
    input  logic [NCH-1:0]        chan_level,
    input  logic [NCH-1:0]        chan_pos_en,
    input  logic [NCH-1:0]        chan_neg_en,
    input  logic                  flag_wr,
    input  logic [NCH-1:0]        flag_wdata,
    output logic [NCH-1:0]        flag_q,
    output logic                  irq,
    output logic                  wake
);
    localparam int PW = NPORT * NCH;

    logic [PW-1:0]    sync_q;
    logic [NCH-1:0]   cur, raw, valid, hit, lvl_wake;
    logic [SEL_W-1:0] sel_q;
    logic [NCH-1:0]   level_q;
    logic             sel_chg;

    pin_sync #(.W(PW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (port_in),
        .q   (sync_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            level_q <= '0;
        end else begin
            sel_q   <= port_sel;
            level_q <= chan_level;
        end
    end

    assign sel_chg = (sel_q != port_sel);

    always_comb begin
        cur = '0;
        raw = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (int'(port_sel) == p) begin
                cur = sync_q[p*NCH +: NCH];
                raw = port_in[p*NCH +: NCH];
            end
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        ch_cfg_t cfg;
        assign cfg      = '{level: chan_level[n], hi_en: chan_pos_en[n], lo_en: chan_neg_en[n]};
        assign valid[n] = sel_ok(n, port_sel);

        pin_chan_det u_det (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg),
            .cfg_chg (sel_chg | (level_q[n] != chan_level[n])),
            .valid   (valid[n]),
            .cur_i   (cur[n]),
            .raw_i   (raw[n]),
            .hit_o   (hit[n]),
            .wake_o  (lvl_wake[n])
        );
    end

    pin_flag_reg #(.N(NCH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (hit),
        .wr_en   (flag_wr),
        .wr_data (flag_wdata),
        .flag_q  (flag_q)
    );

    assign irq  = |flag_q;
    assign wake = irq | (|lvl_wake);

    if (NCH > RSV_CH) begin : g_rsv_chk
        assert_reserved_ch7_R3: assert property (@(posedge clk) disable iff (rst)
            ((int'(port_sel) >= RSV_LO && int'(port_sel) <= RSV_HI) && !flag_q[RSV_CH])
            |=> !flag_q[RSV_CH]);
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(hit) & ~flag_q) == '0));

    assert_set_needs_hit_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0));
endmodule

// File: tb/pin_irq_ctrl_tb_top.sv
module pin_irq_ctrl_tb_top;
    import pin_irq_pkg::*;
    localparam int NC = NUM_CH;
    localparam int NP = NUM_PORT;

    logic clk = 1'b0;
    logic rst;
    logic [NP*NC-1:0] port_in;
    logic [2:0]       sel;
    logic [NC-1:0]    typ, pen, nen, wdata, flag_q;
    logic             wr, irq, wake;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pin_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .port_in(port_in), .port_sel(sel),
        .chan_level(typ), .chan_pos_en(pen), .chan_neg_en(nen),
        .flag_wr(wr), .flag_wdata(wdata), .flag_q(flag_q), .irq(irq), .wake(wake)
    );

    // ---------------- bench model ----------------
    logic [NP*NC-1:0] m_s1, m_s2;
    logic [NC-1:0]    m_prev, m_typ_q, m_flag;
    logic [2:0]       m_sel_q;

    function automatic logic [NC-1:0] pick(input logic [NP*NC-1:0] v, input logic [2:0] s);
        for (int p = 0; p < NP; p++) if (int'(s) == p) return v[p*NC +: NC];
        return '0;
    endfunction

    function automatic logic [NC-1:0] act_mask(input logic [2:0] s);
        logic [NC-1:0] m;
        if (int'(s) >= NP) return '0;
        m = '1;
        if (s == 3'd3 || s == 3'd4) m[7] = 1'b0;
        return m;
    endfunction

    function automatic logic exp_wake(input logic [NC-1:0] fl);
        logic [NC-1:0] r;
        r = pick(port_in, sel);
        return (|fl) | (|(act_mask(sel) & typ & ((pen & r) | (nen & ~r))));
    endfunction

    always @(posedge clk) begin
        logic [NC-1:0] c, h;
        logic s_chg;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_typ_q = '0; m_flag = '0; m_sel_q = '0;
        end else begin
            c = pick(m_s2, sel);
            s_chg = (sel != m_sel_q);
            for (int k = 0; k < NC; k++) begin
                if (typ[k])
                    h[k] = (pen[k] & c[k]) | (nen[k] & ~c[k]);
                else
                    h[k] = !(s_chg || m_typ_q[k] != typ[k]) &&
                           ((pen[k] & c[k] & ~m_prev[k]) | (nen[k] & ~c[k] & m_prev[k]));
            end
            h = h & act_mask(sel);
            m_flag  = (m_flag & (wr ? wdata : '1)) | h;
            m_prev  = c;
            m_s2    = m_s1;
            m_s1    = port_in;
            m_sel_q = sel;
            m_typ_q = typ;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr(input logic [NC-1:0] keep);
        wr = 1'b1; wdata = keep;
        tick(1);
        wr = 1'b0; wdata = '1;
    endtask

    task automatic quiet();
        typ = '0; pen = '0; nen = '0;
        tick(1);
        clr('0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; port_in = '0; sel = '0; typ = '0; pen = '0; nen = '0;
        wr = 1'b0; wdata = '1;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 flags after reset", flag_q, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 wake after reset", wake, 0);

        // R4 rising-edge latency
        pen = 8'h01;
        tick(2);
        port_in[0] = 1'b1;
        tick(2);
        chk("R4 no flag before third edge", flag_q[0], 0);
        tick(1);
        chk("R4 rising edge sets flag", flag_q, 8'h01);
        chk("R9 irq follows flag", irq, 1);
        clr(8'hFF);
        chk("R7 write of one keeps flag", flag_q, 8'h01);
        clr(8'hFE);
        chk("R7 write of zero clears flag", flag_q, 0);
        chk("R9 irq low with no flags", irq, 0);
        tick(3);
        chk("R4 held high level gives no edge", flag_q, 0);

        // R6 falling, both, neither
        pen = 8'h00; nen = 8'h01;
        port_in[0] = 1'b0;
        tick(3);
        chk("R4 falling edge sets flag", flag_q, 8'h01);
        clr('0);
        pen = 8'h01;
        port_in[0] = 1'b1;
        tick(3);
        chk("R6 both enables catch rise", flag_q, 8'h01);
        clr('0);
        port_in[0] = 1'b0;
        tick(3);
        chk("R6 both enables catch fall", flag_q, 8'h01);
        clr('0);
        pen = '0; nen = '0;
        port_in[0] = 1'b1; tick(3); port_in[0] = 1'b0; tick(4);
        chk("R6 no enables never flags", flag_q, 0);

        // R5 / R8 level mode
        typ = 8'h02; nen = 8'h02;
        tick(1);
        chk("R5 low level sets flag", flag_q, 8'h02);
        clr(8'hFD);
        chk("R8 set wins over clear", flag_q, 8'h02);
        port_in[1] = 1'b1;
        tick(3);
        clr(8'hFD);
        chk("R5 level gone, clear sticks", flag_q, 0);
        nen = 8'h00; pen = 8'h02;
        tick(1);
        chk("R5 high level sets flag", flag_q, 8'h02);
        quiet();
        port_in = '0;
        tick(3);
        clr('0);
        chk("R7 flags idle after setup", flag_q, 0);

        // R11 wake without clock edge
        typ = 8'h04; pen = 8'h04;
        tick(1);
        chk("R11 wake low when pin inactive", wake, 0);
        #2 port_in[2] = 1'b1;
        #1;
        chk("R11 wake rises combinationally", wake, 1);
        chk("R11 no flag before clock", flag_q, 0);
        tick(1);
        quiet();
        port_in = '0;
        tick(3);
        clr('0);

        // R10 select change makes no edge
        pen = 8'h01;
        port_in[8] = 1'b1;
        tick(4);
        chk("R10 unselected port ignored", flag_q, 0);
        sel = 3'd1;
        tick(4);
        chk("R10 select switch no rising edge", flag_q, 0);
        nen = 8'h01;
        tick(1);
        sel = 3'd0;
        tick(4);
        chk("R10 select switch no falling edge", flag_q, 0);
        quiet();
        port_in = '0;

        // R3 / R2 reserved and routing
        sel = 3'd3; typ = 8'hC0; nen = 8'hC0;
        tick(3);
        chk("R3 ch7 inactive on code 3, ch6 active", flag_q, 8'h40);
        chk("R11 wake with irq", wake, 1);
        sel = 3'd4;
        tick(1);
        clr(8'hBF);
        tick(2);
        chk("R3 ch7 inactive on code 4", flag_q[7], 0);
        sel = 3'd6;
        tick(1);
        clr('0);
        tick(3);
        chk("R2 code 6 inactive", flag_q, 0);
        sel = 3'd5;
        tick(2);
        chk("R2 code 5 routes port 5", flag_q, 8'hC0);
        quiet();
        typ = '1; pen = '1; sel = 3'd2;
        port_in = {8'h5A, 8'h5A, 8'h5A, 8'hA5, 8'h5A, 8'h5A};
        tick(3);
        chk("R2 port 2 bits to channels", flag_q, 8'hA5);
        quiet();
        port_in = '0; sel = '0;
        tick(3);
        clr('0);

        // random phase against model
        for (int i = 0; i < 4000; i++) begin
            chk("R4 R5 random flags", flag_q, m_flag);
            chk("R9 random irq", irq, |m_flag);
            for (int j = 0; j < 3; j++)
                if ($urandom % 3 == 0) port_in[$urandom % (NP*NC)] ^= 1'b1;
            if ($urandom % 50 == 0) sel = 3'($urandom % 8);
            if ($urandom % 40 == 0) begin
                typ = 8'($urandom); pen = 8'($urandom); nen = 8'($urandom);
            end
            wr = ($urandom % 8 == 0);
            wdata = 8'($urandom);
            #1;
            chk("R11 random wake", wake, exp_wake(m_flag));
            tick(1);
        end
        finish_run();
    end
endmodule